// File: doc/BRIEF.md
# Per-CPU Interrupt Port with Inter-Processor Signalling

This block is the register face that one processor sees of a multiprocessor interrupt controller. Upstream logic, which handles trigger detection and shared routing, presents this CPU with a vector of pending interrupt lines. The block keeps an enable bit and an in-service (active) bit for every interrupt number. It offers software the lowest-numbered interrupt that is pending, enabled and not yet in service, and raises a request line to the processor while such an interrupt exists and the port is switched on.

Software never manipulates bitmaps. To enable, disable or complete an interrupt it writes the interrupt number to a dedicated register. It claims an interrupt by reading the ready register, which marks the returned number as in service. One write to the signalling register sends an inter-processor interrupt that names both a number (0..15) and a set of target CPUs. That request leaves the block on a valid/ready stream. Requests from any CPU arrive on a plain broadcast input, and those that name this CPU are latched as pending.

Outgoing stream rules: `ipi_out_valid` stays high, with `ipi_out_mask` and `ipi_out_id` held stable, until a cycle in which `ipi_out_ready` is high. While an undelivered request is held and `ipi_out_ready` is low, a write to the signalling register is stalled by `wr_ready` being low. A write in the cycle the slot drains is accepted.

Top module: `cpu_irq_port`

## Requirements
- R1: After reset every enable, active and latched inter-processor bit is clear, the port is off, `irq_o` and `ipi_out_valid` are low, and a read of the ready register returns 32'hFFFF_FFFF.
- R2: Bit 0 of the control register (offset 0x00) switches the port on. A read at 0x00 returns that bit in bit 0 and zeros above it.
- R3: Writing a number N to offset 0xA0 enables interrupt N. A number at or above NUM_IRQ is ignored: it does not alias onto the low bits.
- R4: Writing a number N to offset 0xA4 disables interrupt N.
- R5: A read at offset 0x6C returns the lowest N that is pending, enabled and not active. It returns 32'hFFFF_FFFF when there is none. Read data is valid, with `rd_valid` high, in the cycle after `rd_en`.
- R6: A read at 0x6C that returns a number marks it active, so later reads skip it.
- R7: Writing a number N to offset 0xB4 clears its active bit and makes it eligible again.
- R8: `irq_o` is high exactly when the port is on and a ready number exists. It follows `pend_i` in the same cycle.
- R9: A write to offset 0x60 sends an inter-processor request with its number from data bits 3:0 and its target mask from bits 8+NUM_CPU-1:8. Mask bits for CPUs that do not exist are dropped, and a write whose resulting mask is empty sends nothing.
- R10: An outgoing request is held stable until accepted. A second write to 0x60 waits, with `wr_ready` low, while the slot is full and `ipi_out_ready` is low.
- R11: An incoming request whose mask has bit CPU_IDX set makes its number (0..15) pending until this CPU claims it. Requests that do not name this CPU have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | NUM_IRQ | Pending interrupt lines for this CPU |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 32 | Register write data |
| wr_ready | output | 1 | Write accepted this cycle when high |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read offset |
| rd_valid | output | 1 | Read data valid (one cycle after rd_en) |
| rd_data | output | 32 | Read data |
| irq_o | output | 1 | Interrupt request to the processor |
| ipi_in_valid | input | 1 | Incoming inter-processor request strobe |
| ipi_in_mask | input | NUM_CPU | Target CPUs of the incoming request |
| ipi_in_id | input | 4 | Number of the incoming request |
| ipi_out_valid | output | 1 | Outgoing request valid |
| ipi_out_ready | input | 1 | Outgoing request accepted |
| ipi_out_mask | output | NUM_CPU | Target CPUs of the outgoing request |
| ipi_out_id | output | 4 | Number of the outgoing request |

## Verification
The assertions assume a single register write per cycle. They also assume that `ipi_out_ready`, `pend_i` and the incoming request pins carry known values whenever reset is released. The bench changes every input only on the falling edge and keeps them all defined from time zero. It issues one register operation at a time and pulses incoming requests for one cycle. It holds `ipi_out_ready` high during the random phase, so the outgoing slot never back-pressures there.

// File: rtl/cip_pkg.sv
package cip_pkg;
  localparam int unsigned REG_AW  = 8;
  localparam int unsigned REG_DW  = 32;
  localparam int unsigned SGI_IDS = 16;
  localparam int unsigned SGI_IW  = 4;

  // register offsets (software-visible, fixed)
  localparam logic [REG_AW-1:0] OFF_CTL = 8'h00;
  localparam logic [REG_AW-1:0] OFF_SIG = 8'h60;
  localparam logic [REG_AW-1:0] OFF_RDY = 8'h6C;
  localparam logic [REG_AW-1:0] OFF_SEN = 8'hA0;
  localparam logic [REG_AW-1:0] OFF_CEN = 8'hA4;
  localparam logic [REG_AW-1:0] OFF_CMP = 8'hB4;

  // signalling register fields
  localparam int unsigned SIG_ID_LSB   = 0;
  localparam int unsigned SIG_MASK_LSB = 8;
  localparam int unsigned SIG_MASK_W   = 8;

  localparam logic [REG_DW-1:0] NONE_READY = '1;
endpackage

// File: rtl/cip_pick.sv
module cip_pick #(
  parameter int unsigned N  = 64,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  // R5: the chosen number is one of the requesters
  always_comb begin
    if (found) begin
      a_r5_pick_is_request: assert (req[idx]);
    end
  end
endmodule

// File: rtl/cip_ipi_tx.sv
module cip_ipi_tx
  import cip_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_req,
  input  logic [SIG_MASK_W-1:0] load_mask,
  input  logic [SGI_IW-1:0]     load_id,
  output logic                  load_ok,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [NUM_CPU-1:0]    out_mask,
  output logic [SGI_IW-1:0]     out_id
);
  logic [NUM_CPU-1:0] kept_mask;

  assign kept_mask = load_mask[NUM_CPU-1:0];
  assign load_ok   = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_id    <= '0;
    end else if (load_req && load_ok && (kept_mask != '0)) begin
      out_valid <= 1'b1;
      out_mask  <= kept_mask;
      out_id    <= load_id;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r10_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mask) && $stable(out_id));

  a_r9_no_empty_target: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_mask != '0);
endmodule

// File: rtl/cip_ipi_rx.sv
module cip_ipi_rx
  import cip_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned CPU_IDX = 0,
  parameter int unsigned ID_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [NUM_CPU-1:0] in_mask,
  input  logic [SGI_IW-1:0]  in_id,
  input  logic               clr_valid,
  input  logic [ID_W-1:0]    clr_id,
  output logic [SGI_IDS-1:0] pend
);
  logic hit;
  assign hit = in_valid && in_mask[CPU_IDX];

  for (genvar g = 0; g < SGI_IDS; g++) begin : g_bit
    logic set_b, clr_b;
    assign set_b = hit && (in_id == SGI_IW'(g));
    assign clr_b = clr_valid && (clr_id == ID_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)     pend[g] <= 1'b0;
      else if (set_b) pend[g] <= 1'b1;
      else if (clr_b) pend[g] <= 1'b0;
    end
  end

  a_r11_request_latched: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend[$past(in_id)]);
endmodule

// File: rtl/cpu_irq_port.sv
module cpu_irq_port
  import cip_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned CPU_IDX = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [31:0]        wr_data,
  output logic               wr_ready,
  input  logic               rd_en,
  input  logic [7:0]         rd_addr,
  output logic               rd_valid,
  output logic [31:0]        rd_data,
  output logic               irq_o,
  input  logic               ipi_in_valid,
  input  logic [NUM_CPU-1:0] ipi_in_mask,
  input  logic [3:0]         ipi_in_id,
  output logic               ipi_out_valid,
  input  logic               ipi_out_ready,
  output logic [NUM_CPU-1:0] ipi_out_mask,
  output logic [3:0]         ipi_out_id
);
  localparam int unsigned ID_W = $clog2(NUM_IRQ);

  logic               port_on;
  logic [NUM_IRQ-1:0] en_q, act_q;
  logic [SGI_IDS-1:0] sgi_pend;
  logic [NUM_IRQ-1:0] eff_pend, ready_vec;
  logic               found;
  logic [ID_W-1:0]    pick_idx;
  logic               id_ok;
  logic [ID_W-1:0]    wid;
  logic [NUM_IRQ-1:0] wid_vec, claim_vec, cmp_vec;
  logic               wr_sig, tx_ok, claim;
  logic               do_sen, do_cen, do_cmp;

  // write decode
  assign id_ok   = wr_data < REG_DW'(NUM_IRQ);
  assign wid     = wr_data[ID_W-1:0];
  assign wid_vec = NUM_IRQ'(1) << wid;
  assign wr_sig  = wr_en && (wr_addr == OFF_SIG);
  assign wr_ready = (wr_addr != OFF_SIG) || tx_ok;
  assign do_sen  = wr_en && (wr_addr == OFF_SEN) && id_ok;
  assign do_cen  = wr_en && (wr_addr == OFF_CEN) && id_ok;
  assign do_cmp  = wr_en && (wr_addr == OFF_CMP) && id_ok;

  // ready selection
  assign eff_pend  = pend_i | NUM_IRQ'(sgi_pend);
  assign ready_vec = eff_pend & en_q & ~act_q;

  cip_pick #(.N(NUM_IRQ), .IW(ID_W)) u_pick (
    .req   (ready_vec),
    .found (found),
    .idx   (pick_idx)
  );

  assign claim     = rd_en && (rd_addr == OFF_RDY) && found;
  assign claim_vec = claim ? (NUM_IRQ'(1) << pick_idx) : '0;
  assign cmp_vec   = do_cmp ? wid_vec : '0;
  assign irq_o     = port_on && found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_on <= 1'b0;
      en_q    <= '0;
      act_q   <= '0;
    end else begin
      if (wr_en && (wr_addr == OFF_CTL)) port_on <= wr_data[0];
      if (do_sen) en_q <= en_q | wid_vec;
      else if (do_cen) en_q <= en_q & ~wid_vec;
      act_q <= (act_q & ~cmp_vec) | claim_vec;
    end
  end

  // read port, one cycle latency
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        unique case (rd_addr)
          OFF_CTL: rd_data <= {31'd0, port_on};
          OFF_RDY: rd_data <= found ? REG_DW'(pick_idx) : NONE_READY;
          default: rd_data <= '0;
        endcase
      end
    end
  end

  cip_ipi_rx #(.NUM_CPU(NUM_CPU), .CPU_IDX(CPU_IDX), .ID_W(ID_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (ipi_in_valid),
    .in_mask   (ipi_in_mask),
    .in_id     (ipi_in_id),
    .clr_valid (claim),
    .clr_id    (pick_idx),
    .pend      (sgi_pend)
  );

  cip_ipi_tx #(.NUM_CPU(NUM_CPU)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (wr_sig),
    .load_mask (wr_data[SIG_MASK_LSB +: SIG_MASK_W]),
    .load_id   (wr_data[SIG_ID_LSB +: SGI_IW]),
    .load_ok   (tx_ok),
    .out_valid (ipi_out_valid),
    .out_ready (ipi_out_ready),
    .out_mask  (ipi_out_mask),
    .out_id    (ipi_out_id)
  );

  a_r6_claim_marks_active: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> act_q[$past(pick_idx)]);

  a_r7_complete_clears: assert property (@(posedge clk) disable iff (!rst_n)
    do_cmp && !(claim && pick_idx == wid) |=> !act_q[$past(wid)]);

  a_r3_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    do_sen |=> en_q[$past(wid)]);

  a_r5_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

// File: tb/cpu_irq_port_bench.sv
`timescale 1ns/1ps
module cpu_irq_port_bench;
  localparam int NI = 64;
  localparam int NC = 4;
  localparam int CI = 2;
  localparam logic [31:0] NONE = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0] pend_i = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic wr_ready;
  logic rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic irq_o;
  logic ipi_in_valid = 1'b0;
  logic [NC-1:0] ipi_in_mask = '0;
  logic [3:0] ipi_in_id = '0;
  logic ipi_out_valid;
  logic ipi_out_ready = 1'b1;
  logic [NC-1:0] ipi_out_mask;
  logic [3:0] ipi_out_id;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // bench model
  logic [NI-1:0] m_en = '0, m_act = '0;
  logic [15:0]   m_ipi = '0;
  bit            m_on = 1'b0;

  always #2 clk = ~clk;

  cpu_irq_port #(.NUM_IRQ(NI), .NUM_CPU(NC), .CPU_IDX(CI)) u_cpu_irq_port (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .irq_o(irq_o),
    .ipi_in_valid(ipi_in_valid), .ipi_in_mask(ipi_in_mask), .ipi_in_id(ipi_in_id),
    .ipi_out_valid(ipi_out_valid), .ipi_out_ready(ipi_out_ready),
    .ipi_out_mask(ipi_out_mask), .ipi_out_id(ipi_out_id)
  );

  function automatic logic [31:0] exp_ready();
    logic [NI-1:0] v;
    v = (pend_i | NI'(m_ipi)) & m_en & ~m_act;
    for (int i = 0; i < NI; i++) if (v[i]) return 32'(i);
    return NONE;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    if (d < NI) begin
      if (a == 8'hA0) m_en[d[5:0]] = 1'b1;
      if (a == 8'hA4) m_en[d[5:0]] = 1'b0;
      if (a == 8'hB4) m_act[d[5:0]] = 1'b0;
    end
    if (a == 8'h00) m_on = d[0];
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    logic [31:0] e;
    @(negedge clk);
    e = exp_ready();
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_valid ? rd_data : 32'hDEAD_BEEF;
    if (a == 8'h6C && e != NONE) begin
      m_act[e[5:0]] = 1'b1;
      if (e < 16) m_ipi[e[3:0]] = 1'b0;
    end
  endtask

  task automatic send_in(input logic [NC-1:0] m, input logic [3:0] id);
    @(negedge clk);
    ipi_in_valid = 1'b1; ipi_in_mask = m; ipi_in_id = id;
    @(negedge clk);
    ipi_in_valid = 1'b0;
    if (m[CI]) m_ipi[id] = 1'b1;
  endtask

  task automatic check_ready(input string req);
    logic [31:0] e, d;
    @(negedge clk);
    e = exp_ready();
    rd(8'h6C, d);
    check(req, d, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq_o", 32'(irq_o), 0);
    check("R1 ipi_out_valid", 32'(ipi_out_valid), 0);
    rd(8'h6C, d); check("R1 ready none", d, NONE);
    rd(8'h00, d); check("R2 ctl reset", d, 0);

    // R2 port on and readback
    wr(8'h00, 32'h0000_0003);
    rd(8'h00, d); check("R2 ctl readback", d, 1);

    // R3 / R8 enable, out of range ignored
    pend_i = NI'(64'h0000_0000_0000_0228); // bits 3,5,9
    #1 check("R8 irq low when none enabled", 32'(irq_o), 0);
    wr(8'hA0, 32'd67); // 67 & 63 = 3, must not alias
    #1 check("R3 out of range ignored", 32'(irq_o), 0);
    wr(8'hA0, 32'd9);
    #1 check("R8 irq high", 32'(irq_o), 1);
    wr(8'hA0, 32'd5);
    rd(8'h6C, d); check("R5 lowest first", d, 5);
    rd(8'h6C, d); check("R6 claimed skipped", d, 9);
    rd(8'h6C, d); check("R5 none left", d, NONE);
    #1 check("R8 irq low all active", 32'(irq_o), 0);
    wr(8'hB4, 32'd5);
    rd(8'h6C, d); check("R7 complete re-arms", d, 5);
    wr(8'hB4, 32'd5);
    wr(8'hB4, 32'd9);
    wr(8'hA4, 32'd5);
    rd(8'h6C, d); check("R4 disabled skipped", d, 9);
    wr(8'hB4, 32'd9);
    wr(8'h00, 32'd0);
    #1 check("R8 irq low when port off", 32'(irq_o), 0);
    wr(8'h00, 32'd1);
    #1 check("R8 irq high when port on", 32'(irq_o), 1);
    wr(8'hA4, 32'd9);
    pend_i = '0;

    // R9 / R10 outgoing request
    @(negedge clk);
    ipi_out_ready = 1'b0;
    wr(8'h60, 32'h0000_F60A);
    check("R9 out valid", 32'(ipi_out_valid), 1);
    check("R9 mask trimmed", 32'(ipi_out_mask), 32'h6);
    check("R9 id", 32'(ipi_out_id), 32'hA);
    wr_en = 1'b1; wr_addr = 8'h60; wr_data = 32'h0000_0103;
    #1 check("R10 write stalled", 32'(wr_ready), 0);
    @(negedge clk);
    check("R10 held mask", 32'(ipi_out_mask), 32'h6);
    check("R10 held id", 32'(ipi_out_id), 32'hA);
    ipi_out_ready = 1'b1;
    #1 check("R10 ready on drain", 32'(wr_ready), 1);
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 second loaded", 32'(ipi_out_id), 32'h3);
    check("R10 second mask", 32'(ipi_out_mask), 32'h1);
    @(negedge clk);
    check("R9 drained", 32'(ipi_out_valid), 0);
    wr(8'h60, 32'h0000_F007);
    check("R9 empty mask sends nothing", 32'(ipi_out_valid), 0);

    // R11 incoming requests
    wr(8'hA0, 32'd7);
    wr(8'hA0, 32'd8);
    send_in(4'b0100, 4'd7);
    send_in(4'b1011, 4'd8);
    rd(8'h6C, d); check("R11 targeted latched", d, 7);
    wr(8'hB4, 32'd7);
    rd(8'h6C, d); check("R11 cleared by claim, untargeted ignored", d, NONE);

    // random phase
    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom % 6);
      @(negedge clk);
      if (($urandom % 4) == 0) pend_i = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      case (op)
        0: wr(8'hA0, $urandom % (NI + 8));
        1: wr(8'hA4, $urandom % (NI + 8));
        2: wr(8'hB4, $urandom % NI);
        3: send_in(NC'($urandom), 4'($urandom));
        4: wr(8'h00, 32'($urandom % 2));
        default: check_ready("R5 random ready");
      endcase
      #1 check("R8 random irq", 32'(irq_o), 32'(m_on && exp_ready() != NONE));
    end

    finish_run();
  end
endmodule